// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a flow-through synchronous SRAM whose bus never needs an idle cycle between a read and a write. Address, control and byte-lane selects are registered on a rising clock edge. The data transfer for that command takes place in the clock cycle that follows.

Read data flows straight from the array to the output, with no output register. Write data is taken from the bus on the edge that closes the data cycle. A two-bit burst counter lets one loaded address serve a run of four words. The block is meant as a cycle-accurate stand-in for a board-level pipelined SRAM inside a chip-level simulation or an FPGA prototype.

The array is shallow and is loaded with a known pattern on reset, so a test can predict every word without writing it first. The wide tri-state data bus is split into an input port, an output port and an output-enable port.

Top module: `zbt_sram`

## Requirements
- R1: While reset is held, and afterwards until a read command is registered, `dq_oe` is low. Reset loads word i, lane k (bits 9k+8 down to 9k) with (i + 64·k) mod 512.
- R2: A read command is registered on an edge where all of the following hold: `clk_en_n` is low, `adv_ld_n` is low, `ce_a_n` is low, `ce_b` is high, `ce_c_n` is low and `rd_wr_n` is 1. In the cycle after that edge, `dq_out` carries the addressed word and `dq_oe` is high, provided `oe_async_n` is low.
- R3: A write command is the same as in R2 except that `rd_wr_n` is 0. For it, `dq_in` is stored on the edge that ends the following cycle. Only lanes whose `lane_we_n` bit was 0 at command time are written; the other lanes keep their contents.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle. A read registered on the same edge that completes a write to the same word returns the new data.
- R5: If any chip enable is inactive while `adv_ld_n` is low, no operation starts and `dq_oe` is low in the following cycle. A write already in its data cycle at that edge is still stored.
- R6: On an edge where `clk_en_n` is high, every synchronous input is ignored. Pending writes are not stored, and the outputs keep their values.
- R7: `oe_async_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R8: With `adv_ld_n` high after an active command, the next burst word is accessed using the operation type latched at load time. The chip enables and `rd_wr_n` are ignored on such an edge. The low two address bits advance linearly (+1 modulo 4) by default, or as XOR with the count when `BURST_INTERLEAVE` is 1.
- R9: `adv_ld_n` high while no operation is active leaves the block idle, with `dq_oe` low.
- R10: `dq_oe` is low during the data cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, loads the array pattern |
| clk_en_n | input | 1 | Active-low clock enable |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low: load a new command; high: advance the burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | clog2(DEPTH) | Word address |
| lane_we_n | input | 4 | Active-low write select per 9-bit lane |
| oe_async_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Bus input (write data) |
| dq_out | output | 36 | Bus output (read data) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench targets the write-then-read-same-word turnaround. A design that registered read data or delayed the write would return stale data there. It also deselects during a write's data cycle, which catches a design that drops the in-flight write.

Clock-enable stalls are placed both between a write command and its data and during a read. A design that only froze part of the pipeline would store the stall-cycle garbage or lose the read. Burst sequences are checked across the four-word wrap point, and lane-masked writes are checked for disturbance of the neighbouring lanes.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int WORD_W = LANES * LANE_W;

   typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;
endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
   import zbt_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter bit INTERLEAVE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              ce_a_n,
   input  logic              ce_b,
   input  logic              ce_c_n,
   input  logic              adv_ld_n,
   input  logic              rd_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  lane_we_n,
   output logic              cmd_vld,
   output op_e               cmd_op,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [LANES-1:0]  lane_wr
);
   logic              all_sel;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        low_bits;

   assign all_sel = !ce_a_n && ce_b && !ce_c_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld <= 1'b0;
         cmd_op  <= OP_RD;
         base_q  <= '0;
         cnt_q   <= '0;
         lane_wr <= '0;
      end else if (!clk_en_n) begin
         if (!adv_ld_n) begin
            cmd_vld <= all_sel;
            if (all_sel) begin
               cmd_op  <= rd_wr_n ? OP_RD : OP_WR;
               base_q  <= addr;
               cnt_q   <= 2'd0;
               lane_wr <= ~lane_we_n;
            end
         end else if (cmd_vld) begin
            cnt_q   <= cnt_q + 2'd1;
            lane_wr <= ~lane_we_n;
         end
      end
   end

   generate
      if (INTERLEAVE) begin : g_ilv
         assign low_bits = base_q[1:0] ^ cnt_q;
      end else begin : g_lin
         assign low_bits = base_q[1:0] + cnt_q;
      end
   endgenerate

   assign eff_addr = {base_q[ADDR_W-1:2], low_bits};

   // R6
   cen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(cmd_vld) && $stable(eff_addr) && $stable(cmd_op));
   // R5
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld_n && !(!ce_a_n && ce_b && !ce_c_n)) |=> !cmd_vld);
   // R8
   burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv_ld_n && cmd_vld) |=> cmd_vld && $stable(cmd_op));
   // R9
   idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv_ld_n && !cmd_vld) |=> !cmd_vld);
endmodule

// File: rtl/zbt_array.sv
module zbt_array
   import zbt_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [LANES-1:0]  lane_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            for (int k = 0; k < LANES; k++)
               mem[i][k*LANE_W +: LANE_W] <= LANE_W'(i + 64 * k);
      end else if (wr_go) begin
         for (int k = 0; k < LANES; k++)
            if (lane_wr[k])
               mem[addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
   end

   assign rdata = mem[addr];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
         // R3
         lane_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && lane_wr[k]) |=>
               mem[$past(addr)][k*LANE_W +: LANE_W] == $past(wdata[k*LANE_W +: LANE_W]));
         // R3
         lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_go && !lane_wr[k]) |=>
               mem[$past(addr)][k*LANE_W +: LANE_W] == $past(mem[addr][k*LANE_W +: LANE_W]));
      end
   endgenerate
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int DEPTH            = 64,
   parameter bit BURST_INTERLEAVE = 1'b0,
   localparam int ADDR_W          = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              ce_a_n,
   input  logic              ce_b,
   input  logic              ce_c_n,
   input  logic              adv_ld_n,
   input  logic              rd_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        lane_we_n,
   input  logic              oe_async_n,
   input  logic [35:0]       dq_in,
   output logic [35:0]       dq_out,
   output logic              dq_oe
);
   generate
      if (DEPTH < 16 || DEPTH > 256 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two from 16 to 256");
      end
      if (WORD_W != 36) begin : g_bad_word
         $error("word width must be 36");
      end
   endgenerate

   logic              cmd_vld;
   op_e               cmd_op;
   logic [ADDR_W-1:0] eff_addr;
   logic [LANES-1:0]  lane_wr;
   logic              wr_go;

   zbt_cmd_stage #(.ADDR_W(ADDR_W), .INTERLEAVE(BURST_INTERLEAVE)) i_cmd (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .adv_ld_n(adv_ld_n), .rd_wr_n(rd_wr_n), .addr(addr),
      .lane_we_n(lane_we_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .eff_addr(eff_addr), .lane_wr(lane_wr)
   );

   assign wr_go = cmd_vld && (cmd_op == OP_WR) && !clk_en_n;

   zbt_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_array (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .lane_wr(lane_wr),
      .addr(eff_addr), .wdata(dq_in), .rdata(dq_out)
   );

   assign dq_oe = cmd_vld && (cmd_op == OP_RD) && !oe_async_n;

   // R7
   oe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_async_n || !cmd_vld) |-> !dq_oe);
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
   localparam int DEPTH = 64;
   localparam int AW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
   logic          adv_ld_n = 1'b0, rd_wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [3:0]    lane_we_n = 4'hF;
   logic          oe_async_n = 1'b0;
   logic [35:0]   dq_in = '0;
   logic [35:0]   dq_out;
   logic          dq_oe;

   int n_chk = 0, n_fail = 0;
   logic [35:0] model [DEPTH];

   zbt_sram #(.DEPTH(DEPTH)) i_zbt_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .adv_ld_n(adv_ld_n), .rd_wr_n(rd_wr_n), .addr(addr),
      .lane_we_n(lane_we_n), .oe_async_n(oe_async_n), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #10 clk = ~clk;

   localparam logic [2:0] SEL = 3'b010, DES = 3'b110;

   function automatic logic [35:0] init_word(int i);
      logic [35:0] w;
      for (int k = 0; k < 4; k++) w[k*9 +: 9] = 9'((i + 64 * k) % 512);
      return w;
   endfunction

   task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one cycle of inputs at negedge, then sample 5 ns after the next rising edge
   task automatic drv(logic cen, logic adv, logic rw, logic [AW-1:0] a,
                      logic [3:0] we, logic [2:0] sel, logic [35:0] d);
      @(negedge clk);
      clk_en_n = cen; adv_ld_n = adv; rd_wr_n = rw; addr = a;
      lane_we_n = we; {ce_a_n, ce_b, ce_c_n} = sel; dq_in = d;
      @(posedge clk);
      #5;
   endtask

   task automatic idle();
      drv(1'b0, 1'b0, 1'b1, '0, 4'hF, DES, '0);
   endtask

   task automatic t_reset();
      chk("R1 oe after reset", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b0, 1'b1, 6'd5, 4'hF, SEL, '0);
      chk("R1 init pattern", dq_out, init_word(5));
      chk("R2 read drives bus", 36'(dq_oe), 36'd1);
      drv(1'b0, 1'b0, 1'b1, 6'd63, 4'hF, SEL, '0);
      chk("R1 init pattern top word", dq_out, init_word(63));
      idle();
      chk("R5 deselect tri-states", 36'(dq_oe), 36'd0);
   endtask

   task automatic t_turnaround();
      logic [35:0] v = 36'h9_1234_5678;
      drv(1'b0, 1'b0, 1'b0, 6'd3, 4'h0, SEL, '0);
      chk("R10 write data cycle bus off", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b0, 1'b1, 6'd3, 4'hF, SEL, v);
      model[3] = v;
      chk("R4 read right after write", dq_out, v);
      chk("R4 read bus on", 36'(dq_oe), 36'd1);
      drv(1'b0, 1'b0, 1'b0, 6'd4, 4'h0, SEL, '0);
      chk("R10 write after read bus off", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b0, 1'b1, 6'd8, 4'hF, SEL, 36'h0_AAAA_5555);
      model[4] = 36'h0_AAAA_5555;
      chk("R4 read after write other word", dq_out, model[8]);
      drv(1'b0, 1'b0, 1'b1, 6'd4, 4'hF, SEL, '0);
      chk("R2 read back written word", dq_out, model[4]);
      idle();
   endtask

   task automatic t_lanes();
      logic [35:0] v = 36'hF_FFFF_FFFF;
      drv(1'b0, 1'b0, 1'b0, 6'd7, 4'b1010, SEL, '0);
      drv(1'b0, 1'b0, 1'b1, 6'd7, 4'hF, SEL, v);
      model[7][8:0]   = 9'h1FF;
      model[7][26:18] = 9'h1FF;
      chk("R3 lane-masked write", dq_out, model[7]);
      idle();
   endtask

   task automatic t_deselect();
      logic [35:0] v = 36'h1_0F0F_0F0F;
      drv(1'b0, 1'b0, 1'b0, 6'd9, 4'h0, SEL, '0);
      drv(1'b0, 1'b0, 1'b1, 6'd10, 4'hF, 3'b011, v);
      model[9] = v;
      chk("R5 deselect no new op", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b0, 1'b1, 6'd9, 4'hF, SEL, '0);
      chk("R5 pending write completed", dq_out, model[9]);
      idle();
   endtask

   task automatic t_cen();
      logic [35:0] good = 36'h3_CAFE_BEEF;
      drv(1'b0, 1'b0, 1'b0, 6'd20, 4'h0, SEL, '0);
      drv(1'b1, 1'b0, 1'b1, 6'd21, 4'hF, SEL, 36'h0_DEAD_0000);
      chk("R6 stall keeps write pending", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b0, 1'b1, 6'd20, 4'hF, SEL, good);
      model[20] = good;
      chk("R6 stall garbage not stored", dq_out, good);
      drv(1'b0, 1'b0, 1'b1, 6'd2, 4'hF, SEL, '0);
      drv(1'b1, 1'b0, 1'b0, 6'd30, 4'h0, DES, 36'h1_1111_1111);
      chk("R6 read held during stall", dq_out, model[2]);
      chk("R6 bus held during stall", 36'(dq_oe), 36'd1);
      idle();
      drv(1'b0, 1'b0, 1'b1, 6'd30, 4'hF, SEL, '0);
      chk("R6 stalled write cmd ignored", dq_out, model[30]);
      idle();
   endtask

   task automatic t_oe();
      drv(1'b0, 1'b0, 1'b1, 6'd11, 4'hF, SEL, '0);
      oe_async_n = 1'b1;
      #1;
      chk("R7 async oe off", 36'(dq_oe), 36'd0);
      oe_async_n = 1'b0;
      #1;
      chk("R7 async oe back on", 36'(dq_oe), 36'd1);
      idle();
   endtask

   task automatic t_burst();
      drv(1'b0, 1'b0, 1'b1, 6'd6, 4'hF, SEL, '0);
      chk("R8 burst word 0", dq_out, model[6]);
      drv(1'b0, 1'b1, 1'b0, 6'd0, 4'h0, DES, '0);
      chk("R8 burst word 1 kept read", dq_out, model[7]);
      chk("R8 burst stays read", 36'(dq_oe), 36'd1);
      drv(1'b0, 1'b1, 1'b1, 6'd0, 4'hF, SEL, '0);
      chk("R8 burst wrap", dq_out, model[4]);
      drv(1'b0, 1'b1, 1'b1, 6'd0, 4'hF, SEL, '0);
      chk("R8 burst word 3", dq_out, model[5]);
      drv(1'b0, 1'b0, 1'b0, 6'd13, 4'h0, SEL, '0);
      drv(1'b0, 1'b1, 1'b1, 6'd0, 4'h0, SEL, 36'h0_0000_0013);
      drv(1'b0, 1'b1, 1'b1, 6'd0, 4'h0, SEL, 36'h0_0000_0014);
      drv(1'b0, 1'b0, 1'b1, 6'd0, 4'hF, DES, 36'h0_0000_0015);
      model[13] = 36'h13; model[14] = 36'h14; model[15] = 36'h15;
      for (int a = 12; a < 16; a++) begin
         drv(1'b0, 1'b0, 1'b1, 6'(a), 4'hF, SEL, '0);
         chk("R8 burst write result", dq_out, model[a]);
      end
      idle();
      drv(1'b0, 1'b1, 1'b1, 6'd1, 4'hF, SEL, '0);
      chk("R9 advance while idle", 36'(dq_oe), 36'd0);
      drv(1'b0, 1'b1, 1'b0, 6'd1, 4'h0, SEL, 36'h7);
      drv(1'b0, 1'b0, 1'b1, 6'd0, 4'hF, SEL, '0);
      chk("R9 idle advance wrote nothing", dq_out, model[0]);
      idle();
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = init_word(i);
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", 36'(dq_oe), 36'd0);
      rst_n = 1'b1;
      @(posedge clk); #5;
      t_reset();
      t_turnaround();
      t_lanes();
      t_deselect();
      t_cen();
      t_oe();
      t_burst();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule